// File: doc/BRIEF.md
# Device-Side Disk Task File Register Block

This block sits at the device end of a parallel AT-style disk host interface. It decodes two chip selects and a three-bit address, qualified by one-cycle read and write strobes. It holds the 8-bit command-block registers, the control-block registers and a 16-bit data port. It also drives the interrupt request pin together with its output enable. On the device side it gives the firmware a one-cycle command strobe with the opcode, the decoded transfer parameters, and a software-reset level. The firmware in turn supplies status flags, a completion pulse, and an error code.

Several host accesses have side effects. While the device is busy, every command-block read returns status. Reading the primary status copy acknowledges the interrupt, and reading the alternate copy leaves it pending. Writing the command register makes the device busy at once. Host strobes are synchronous single-cycle pulses, and read data is presented combinationally in the strobe cycle. The data buffer and command execution live outside this block.

Top module: `drv_taskfile`

## Requirements
- R1: With only `cs0` high, writes to addresses 2..6 load sector count, sector number, cylinder low, cylinder high and drive/head, and reads return them. Cylinder high keeps 3 bits and reads its upper 5 bits as zero. Drive/head reads as `{1,0,1,dev,head[3:0]}`, where `dev` is written bit 4.
- R2: After `rst_n` falls, status reads 0x00 plus the RDY flag, error reads 0x01, sector count and sector number read 0x01, cylinders and drive/head fields are zero, and interrupts are disabled (`irq_oe` low).
- R3: The status byte is, from bit 7 down, BSY, RDY, WF, SC, DRQ, CORR, IDX, ERR. While BSY is 1, a read of any `cs0` address returns it. With only `cs1` high, address 6 returns it at all times.
- R4: A selected read of `cs0` address 7 clears the pending interrupt. A read of `cs1` address 6 leaves it pending.
- R5: A write to `cs0` address 7 while not busy with RDY=1 and WF=0 sets BSY and clears ERR by the next cycle. In that same next cycle it pulses `cmd_valid` for exactly one cycle, with `cmd_code` equal to the written byte.
- R6: A command write while RDY=0 or WF=1 is refused: no `cmd_valid`, BSY stays 0, ERR is set, the error register becomes 0x04 (abort, bit 2), and an interrupt becomes pending.
- R7: While BSY is 1, writes to every `cs0` address are ignored.
- R8: A `fw_done` pulse while busy clears BSY, copies `fw_err` into ERR, loads `fw_err_code` into the error register when `fw_err` is set, and makes an interrupt pending.
- R9: `cs1` address 6 writes device control, where bit 1 disables interrupts and bit 2 is software reset. While bit 1 is set, `irq_oe` is low and a pending interrupt is kept. It drives `irq_out` high again once bit 1 is cleared.
- R10: While software reset is set, BSY reads 1 and the task file returns to its R2 values. After release, BSY stays 1 until `fw_done`.
- R11: When drive/head bit 4 differs from `dev_is_slave`, reads do not drive the bus (`rdata_oe` low).
- R12: `fw_count` equals sector count, except that a sector count of 0 gives 256.
- R13: `cs1` address 7 reads `{0, wr_gate, head[3:0], ds[1:0]}`, where `ds` is 2'b10 with the master (bit 4 = 0) selected and 2'b01 with the slave selected.
- R14: `cs0` address 0 reads the 16-bit `buf_rdata` when not busy, with a `buf_rd` strobe. Writes to it raise `buf_wr` with `buf_wdata` equal to `wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low |
| dev_is_slave | input | 1 | Strap: this device answers to drive/head bit 4 = 1 |
| cs0 | input | 1 | Command-block select |
| cs1 | input | 1 | Control-block select |
| addr | input | 3 | Register address |
| rd_stb | input | 1 | One-cycle host read strobe |
| wr_stb | input | 1 | One-cycle host write strobe |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| rdata_oe | output | 1 | Read data bus enable |
| irq_out | output | 1 | Interrupt request level |
| irq_oe | output | 1 | Interrupt pin enable (low = tristated) |
| buf_rdata | input | 16 | Word from the sector buffer |
| buf_rd | output | 1 | Buffer word consumed |
| buf_wr | output | 1 | Buffer word written |
| buf_wdata | output | 16 | Word to the sector buffer |
| fw_flags | input | 6 | RDY, WF, SC, DRQ, CORR, IDX (bit 5 down to 0) |
| wr_gate | input | 1 | Write gate level for the digital input register |
| fw_done | input | 1 | Command completion pulse |
| fw_err | input | 1 | Completion ended with an error |
| fw_err_code | input | 8 | Error register value on error |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Command opcode |
| srst_out | output | 1 | Software reset level |
| fw_count | output | 9 | Sector count, 1..256 |
| fw_sector | output | 8 | Target sector number |
| fw_cyl | output | 11 | Target cylinder |
| fw_head | output | 4 | Target head |
| fw_slave | output | 1 | Drive select bit |

## Verification
The properties assume that `rd_stb` and `wr_stb` are never high in the same cycle. They also assume that `fw_done` only arrives while the device is busy. The bench keeps to this because its tasks issue one access per strobe cycle and pulse completion only after an accepted command or a released reset. Random accesses go only to the five plain command-block registers and may flip the drive select bit, so the bench model predicts whether the bus is driven at all. The bench restores the master selection before each directed sequence.

// File: rtl/drv_tf_pkg.sv
package drv_tf_pkg;

    localparam int CYL_HI_W = 3;
    localparam int HEAD_W   = 4;
    localparam int FLAG_W   = 6;
    localparam int CNT_W    = 9;

    localparam logic [7:0] ERR_ABORT   = 8'h04;
    localparam logic [7:0] ERR_DIAG_OK = 8'h01;
    localparam logic [2:0] DRVHD_FIXED = 3'b101;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_DATA,
        ACC_ERR,
        ACC_COUNT,
        ACC_SECT,
        ACC_CYLLO,
        ACC_CYLHI,
        ACC_DRVHD,
        ACC_STATCMD,
        ACC_ALTCTL,
        ACC_DIN
    } acc_e;

    typedef struct packed {
        logic bsy;
        logic rdy;
        logic wf;
        logic sc;
        logic drq;
        logic corr;
        logic idx;
        logic err;
    } status_t;

    typedef struct packed {
        status_t             stat;
        logic [7:0]          err;
        logic [7:0]          count;
        logic [7:0]          sect;
        logic [7:0]          cyl_lo;
        logic [CYL_HI_W-1:0] cyl_hi;
        logic                slave;
        logic [HEAD_W-1:0]   head;
        logic                srst;
        logic                nien;
        logic                irq_pend;
        logic                cmd_pulse;
        logic [7:0]          cmd_code;
    } tf_state_t;

    function automatic tf_state_t tf_reset_state();
        tf_state_t s;
        s       = '0;
        s.err   = ERR_DIAG_OK;
        s.count = 8'h01;
        s.sect  = 8'h01;
        s.nien  = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/drv_tf_decode.sv
module drv_tf_decode
    import drv_tf_pkg::*;
(
    input  logic       cs0,
    input  logic       cs1,
    input  logic [2:0] addr,
    output acc_e       acc
);
    always_comb begin
        acc = ACC_NONE;
        if (cs0 && !cs1) begin
            case (addr)
                3'd0:    acc = ACC_DATA;
                3'd1:    acc = ACC_ERR;
                3'd2:    acc = ACC_COUNT;
                3'd3:    acc = ACC_SECT;
                3'd4:    acc = ACC_CYLLO;
                3'd5:    acc = ACC_CYLHI;
                3'd6:    acc = ACC_DRVHD;
                default: acc = ACC_STATCMD;
            endcase
        end else if (cs1 && !cs0) begin
            if (addr == 3'd6)      acc = ACC_ALTCTL;
            else if (addr == 3'd7) acc = ACC_DIN;
        end
    end
endmodule

// File: rtl/drv_tf_rdmux.sv
module drv_tf_rdmux
    import drv_tf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  acc_e              acc,
    input  logic              busy,
    input  logic [7:0]        stat_b,
    input  logic [7:0]        err_b,
    input  logic [7:0]        count_b,
    input  logic [7:0]        sect_b,
    input  logic [7:0]        cyllo_b,
    input  logic [7:0]        cylhi_b,
    input  logic [7:0]        drvhd_b,
    input  logic [7:0]        din_b,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [DATA_W-1:0] data,
    output logic              hit
);
    localparam int PAD_W = DATA_W - 8;

    logic [7:0] byte_v;
    logic       cmd_blk;

    always_comb begin
        cmd_blk = (acc != ACC_NONE) && (acc != ACC_ALTCTL) && (acc != ACC_DIN);
        hit     = (acc != ACC_NONE);
        byte_v  = 8'h00;
        case (acc)
            ACC_ERR:     byte_v = err_b;
            ACC_COUNT:   byte_v = count_b;
            ACC_SECT:    byte_v = sect_b;
            ACC_CYLLO:   byte_v = cyllo_b;
            ACC_CYLHI:   byte_v = cylhi_b;
            ACC_DRVHD:   byte_v = drvhd_b;
            ACC_STATCMD: byte_v = stat_b;
            ACC_ALTCTL:  byte_v = stat_b;
            ACC_DIN:     byte_v = din_b;
            default:     byte_v = 8'h00;
        endcase
        if (cmd_blk && busy)
            data = {{PAD_W{1'b0}}, stat_b};
        else if (acc == ACC_DATA)
            data = buf_rdata;
        else
            data = {{PAD_W{1'b0}}, byte_v};
    end
endmodule

// File: rtl/drv_taskfile.sv
module drv_taskfile
    import drv_tf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dev_is_slave,
    input  logic                   cs0,
    input  logic                   cs1,
    input  logic [2:0]             addr,
    input  logic                   rd_stb,
    input  logic                   wr_stb,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rdata_oe,
    output logic                   irq_out,
    output logic                   irq_oe,
    input  logic [DATA_W-1:0]      buf_rdata,
    output logic                   buf_rd,
    output logic                   buf_wr,
    output logic [DATA_W-1:0]      buf_wdata,
    input  logic [FLAG_W-1:0]      fw_flags,
    input  logic                   wr_gate,
    input  logic                   fw_done,
    input  logic                   fw_err,
    input  logic [7:0]             fw_err_code,
    output logic                   cmd_valid,
    output logic [7:0]             cmd_code,
    output logic                   srst_out,
    output logic [CNT_W-1:0]       fw_count,
    output logic [7:0]             fw_sector,
    output logic [CYL_HI_W+7:0]    fw_cyl,
    output logic [HEAD_W-1:0]      fw_head,
    output logic                   fw_slave
);
    localparam int CYL_PAD = 8 - CYL_HI_W;
    localparam int DS_W    = 8 - 2 - HEAD_W;

    tf_state_t state_q, state_d;
    acc_e      acc;
    logic      selected, rd_hit, wr_cmdblk;
    logic      mux_hit;
    logic [DATA_W-1:0] mux_data;
    logic [7:0] drvhd_b, din_b, cylhi_b;

    drv_tf_decode u_dec (
        .cs0  (cs0),
        .cs1  (cs1),
        .addr (addr),
        .acc  (acc)
    );

    assign drvhd_b = {DRVHD_FIXED, state_q.slave, state_q.head};
    assign cylhi_b = {{CYL_PAD{1'b0}}, state_q.cyl_hi};
    assign din_b   = {1'b0, wr_gate, state_q.head,
                      state_q.slave ? DS_W'(2'b01) : DS_W'(2'b10)};

    drv_tf_rdmux #(.DATA_W(DATA_W)) u_mux (
        .acc       (acc),
        .busy      (state_q.stat.bsy),
        .stat_b    (state_q.stat),
        .err_b     (state_q.err),
        .count_b   (state_q.count),
        .sect_b    (state_q.sect),
        .cyllo_b   (state_q.cyl_lo),
        .cylhi_b   (cylhi_b),
        .drvhd_b   (drvhd_b),
        .din_b     (din_b),
        .buf_rdata (buf_rdata),
        .data      (mux_data),
        .hit       (mux_hit)
    );

    always_comb begin
        selected  = (state_q.slave == dev_is_slave);
        rd_hit    = rd_stb && selected && mux_hit;
        wr_cmdblk = wr_stb && !state_q.stat.bsy &&
                    (acc != ACC_NONE) && (acc != ACC_ALTCTL) && (acc != ACC_DIN);

        state_d           = state_q;
        state_d.cmd_pulse = 1'b0;

        if (state_q.srst) begin
            state_d          = tf_reset_state();
            state_d.srst     = state_q.srst;
            state_d.nien     = state_q.nien;
            state_d.stat.bsy = 1'b1;
        end else begin
            if (wr_cmdblk) begin
                case (acc)
                    ACC_COUNT: state_d.count  = wdata[7:0];
                    ACC_SECT:  state_d.sect   = wdata[7:0];
                    ACC_CYLLO: state_d.cyl_lo = wdata[7:0];
                    ACC_CYLHI: state_d.cyl_hi = wdata[CYL_HI_W-1:0];
                    ACC_DRVHD: begin
                        state_d.slave = wdata[4];
                        state_d.head  = wdata[HEAD_W-1:0];
                    end
                    ACC_STATCMD: begin
                        if (state_q.stat.rdy && !state_q.stat.wf) begin
                            state_d.stat.bsy = 1'b1;
                            state_d.stat.err = 1'b0;
                            state_d.cmd_pulse = 1'b1;
                            state_d.cmd_code  = wdata[7:0];
                        end else begin
                            state_d.stat.err = 1'b1;
                            state_d.err      = ERR_ABORT;
                            state_d.irq_pend = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_hit && acc == ACC_STATCMD)
                state_d.irq_pend = 1'b0;
            if (fw_done && state_q.stat.bsy) begin
                state_d.stat.bsy = 1'b0;
                state_d.stat.err = fw_err;
                if (fw_err)
                    state_d.err = fw_err_code;
                state_d.irq_pend = 1'b1;
            end
        end

        if (wr_stb && acc == ACC_ALTCTL) begin
            state_d.srst = wdata[2];
            state_d.nien = wdata[1];
        end

        {state_d.stat.rdy, state_d.stat.wf, state_d.stat.sc,
         state_d.stat.drq, state_d.stat.corr, state_d.stat.idx} = fw_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= tf_reset_state();
        else        state_q <= state_d;
    end

    assign rdata     = rd_hit ? mux_data : '0;
    assign rdata_oe  = rd_hit;
    assign irq_out   = state_q.irq_pend;
    assign irq_oe    = !state_q.nien;
    assign buf_rd    = rd_hit && (acc == ACC_DATA) && !state_q.stat.bsy;
    assign buf_wr    = wr_cmdblk && selected && (acc == ACC_DATA);
    assign buf_wdata = wdata;
    assign cmd_valid = state_q.cmd_pulse;
    assign cmd_code  = state_q.cmd_code;
    assign srst_out  = state_q.srst;
    assign fw_count  = (state_q.count == 8'h00) ? CNT_W'(256) : CNT_W'(state_q.count);
    assign fw_sector = state_q.sect;
    assign fw_cyl    = {state_q.cyl_hi, state_q.cyl_lo};
    assign fw_head   = state_q.head;
    assign fw_slave  = state_q.slave;

endmodule

// File: rtl/drv_tf_checker.sv
module drv_tf_checker
    import drv_tf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_is_slave,
    input logic              cs0,
    input logic              cs1,
    input logic [2:0]        addr,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              fw_done,
    input logic              cmd_valid,
    input logic [CNT_W-1:0]  fw_count,
    input tf_state_t         state_q
);
    // R3: busy reads on the command block deliver status
    assert_busy_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && cs0 && !cs1 && state_q.stat.bsy && rdata_oe)
        |-> (rdata[7:0] == state_q.stat));

    // R4: primary status read acknowledges the interrupt
    assert_status_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && cs0 && !cs1 && addr == 3'd7 && rdata_oe && !fw_done)
        |=> !state_q.irq_pend);

    // R4: alternate status read keeps it pending
    assert_alt_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && cs1 && !cs0 && addr == 3'd6 &&
         state_q.irq_pend && !state_q.srst)
        |=> state_q.irq_pend);

    // R5: command strobe only while busy, one cycle wide
    assert_cmd_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> state_q.stat.bsy);
    assert_cmd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7: sector number writes while busy have no effect
    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cs0 && !cs1 && addr == 3'd3 && state_q.stat.bsy && !state_q.srst)
        |=> $stable(state_q.sect));

    // R9: masking keeps the pending interrupt
    assert_mask_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cs1 && !cs0 && addr == 3'd6 && state_q.irq_pend && !state_q.srst)
        |=> state_q.irq_pend);

    // R11: unselected device stays off the bus
    assert_unselected_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.slave != dev_is_slave) |-> !rdata_oe);

    // R12: firmware count is never zero
    assert_count_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_count != '0) && (fw_count <= CNT_W'(256)));
endmodule

bind drv_taskfile drv_tf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_is_slave (dev_is_slave),
    .cs0          (cs0),
    .cs1          (cs1),
    .addr         (addr),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .rdata        (rdata),
    .rdata_oe     (rdata_oe),
    .fw_done      (fw_done),
    .cmd_valid    (cmd_valid),
    .fw_count     (fw_count),
    .state_q      (state_q)
);

// File: tb/drv_taskfile_test.sv
module drv_taskfile_test;
    import drv_tf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_is_slave = 1'b0;
    logic        cs0 = 1'b0, cs1 = 1'b0;
    logic [2:0]  addr = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rdata_oe, irq_out, irq_oe;
    logic [15:0] buf_rdata = 16'hBEEF;
    logic        buf_rd, buf_wr;
    logic [15:0] buf_wdata;
    logic [5:0]  fw_flags = 6'b100000;
    logic        wr_gate = 1'b0;
    logic        fw_done = 1'b0, fw_err = 1'b0;
    logic [7:0]  fw_err_code = '0;
    logic        cmd_valid, srst_out, fw_slave;
    logic [7:0]  cmd_code, fw_sector;
    logic [8:0]  fw_count;
    logic [10:0] fw_cyl;
    logic [3:0]  fw_head;

    int n_vec = 0, n_bad = 0;
    logic        finished = 1'b0;
    logic [15:0] rv;
    logic        roe;
    logic [7:0]  m_count = 8'h01, m_sect = 8'h01, m_cyllo = 8'h00;
    logic [2:0]  m_cylhi = 3'h0;
    logic        m_slave = 1'b0;
    logic [3:0]  m_head = 4'h0;

    always #5 clk = ~clk;

    drv_taskfile uut (.*);

    function automatic logic [7:0] exp_drvhd(input logic s, input logic [3:0] h);
        return {3'b101, s, h};
    endfunction

    function automatic logic [7:0] exp_reg(input int a);
        case (a)
            2: return m_count;
            3: return m_sect;
            4: return m_cyllo;
            5: return {5'b0, m_cylhi};
            default: return exp_drvhd(m_slave, m_head);
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic c0, input logic c1, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cs0 = c0; cs1 = c1; addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; cs0 = 1'b0; cs1 = 1'b0;
        #1;
    endtask

    task automatic hread(input logic c0, input logic c1, input logic [2:0] a);
        @(negedge clk);
        cs0 = c0; cs1 = c1; addr = a; rd_stb = 1'b1;
        #1;
        rv = rdata; roe = rdata_oe;
        @(negedge clk);
        rd_stb = 1'b0; cs0 = 1'b0; cs1 = 1'b0;
        #1;
    endtask

    task automatic done_pulse(input logic e, input logic [7:0] code);
        @(negedge clk);
        fw_done = 1'b1; fw_err = e; fw_err_code = code;
        @(negedge clk);
        fw_done = 1'b0; fw_err = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 reset state
        hread(1, 0, 3'd7); check("R2 status", rv[7:0], 8'h40);
        hread(1, 0, 3'd1); check("R2 error", rv[7:0], 8'h01);
        hread(1, 0, 3'd2); check("R2 count", rv[7:0], 8'h01);
        hread(1, 0, 3'd3); check("R2 sector", rv[7:0], 8'h01);
        hread(1, 0, 3'd6); check("R2 drvhd", rv[7:0], 8'hA0);
        check("R2 irq disabled", irq_oe, 1'b0);

        // R1 R11 random register traffic
        for (int i = 0; i < 60; i++) begin
            int a;
            logic [7:0] v;
            a = $urandom_range(2, 6);
            v = 8'($urandom);
            hwrite(1, 0, 3'(a), {8'h00, v});
            case (a)
                2: m_count = v;
                3: m_sect = v;
                4: m_cyllo = v;
                5: m_cylhi = v[2:0];
                default: begin m_slave = v[4]; m_head = v[3:0]; end
            endcase
            for (int r = 2; r <= 6; r++) begin
                hread(1, 0, 3'(r));
                check("R11 bus enable", roe, m_slave == 1'b0);
                if (roe) check("R1 readback", rv, {8'h00, exp_reg(r)});
            end
        end
        hwrite(1, 0, 3'd6, 16'h0000); m_slave = 0; m_head = 0;

        // R11 directed
        hwrite(1, 0, 3'd6, 16'h0010);
        hread(0, 1, 3'd6); check("R11 unselected alt read", roe, 1'b0);
        hwrite(1, 0, 3'd6, 16'h0000);

        // R12
        hwrite(1, 0, 3'd2, 16'h0000); check("R12 zero count", fw_count, 9'd256);
        hwrite(1, 0, 3'd2, 16'h0005); check("R12 count", fw_count, 9'd5);
        hwrite(1, 0, 3'd3, 16'h0033); m_sect = 8'h33;

        // R5 R3 R7 R8 R4
        hwrite(0, 1, 3'd6, 16'h0000); check("R9 enabled", irq_oe, 1'b1);
        hwrite(1, 0, 3'd7, 16'h0020);
        check("R5 cmd_valid", cmd_valid, 1'b1);
        check("R5 cmd_code", cmd_code, 8'h20);
        hread(1, 0, 3'd7); check("R5 busy status", rv[7:0], 8'hC0);
        check("R5 single pulse", cmd_valid, 1'b0);
        hread(1, 0, 3'd2); check("R3 redirect", rv[7:0], 8'hC0);
        hread(0, 1, 3'd6); check("R3 alt busy", rv[7:0], 8'hC0);
        hwrite(1, 0, 3'd3, 16'h0077);
        hwrite(1, 0, 3'd7, 16'h0030); check("R7 cmd ignored", cmd_valid, 1'b0);
        done_pulse(0, 8'h00);
        check("R8 irq", irq_out, 1'b1);
        hread(0, 1, 3'd6); check("R8 status", rv[7:0], 8'h40);
        check("R4 alt keeps irq", irq_out, 1'b1);
        hread(1, 0, 3'd3); check("R7 sector kept", rv[7:0], m_sect);
        hread(1, 0, 3'd7); check("R4 status", rv[7:0], 8'h40);
        check("R4 status clears irq", irq_out, 1'b0);

        // R9
        hwrite(1, 0, 3'd7, 16'h0030); done_pulse(0, 8'h00);
        hwrite(0, 1, 3'd6, 16'h0002);
        check("R9 tristate", irq_oe, 1'b0);
        check("R9 pending kept", irq_out, 1'b1);
        hwrite(0, 1, 3'd6, 16'h0000);
        check("R9 re-enabled", irq_oe, 1'b1);
        check("R9 reasserted", irq_out, 1'b1);
        hread(1, 0, 3'd7);

        // R8 with error, then next command clears ERR
        hwrite(1, 0, 3'd7, 16'h0040); done_pulse(1, 8'h10);
        hread(1, 0, 3'd7); check("R8 err status", rv[7:0], 8'h41);
        hread(1, 0, 3'd1); check("R8 err code", rv[7:0], 8'h10);
        hwrite(1, 0, 3'd7, 16'h0070);
        hread(0, 1, 3'd6); check("R5 err cleared", rv[7:0], 8'hC0);
        done_pulse(0, 8'h00); hread(1, 0, 3'd7);

        // R6 abort
        @(negedge clk); fw_flags = 6'b000000; @(negedge clk);
        hwrite(1, 0, 3'd7, 16'h0020);
        check("R6 no strobe", cmd_valid, 1'b0);
        hread(0, 1, 3'd6); check("R6 status", rv[7:0], 8'h01);
        hread(1, 0, 3'd1); check("R6 abort code", rv[7:0], 8'h04);
        check("R6 irq", irq_out, 1'b1);
        @(negedge clk); fw_flags = 6'b110000; @(negedge clk);
        hwrite(1, 0, 3'd7, 16'h0020);
        check("R6 wf no strobe", cmd_valid, 1'b0);
        hread(1, 0, 3'd7); check("R6 wf status", rv[7:0], 8'h61);
        @(negedge clk); fw_flags = 6'b100000; @(negedge clk);

        // R13 R14
        wr_gate = 1'b1;
        hwrite(1, 0, 3'd6, 16'h0005);
        hread(0, 1, 3'd7); check("R13 digital input", rv[7:0], 8'h56);
        hread(1, 0, 3'd0); check("R14 data word", rv, 16'hBEEF);
        @(negedge clk);
        cs0 = 1; addr = 3'd0; wdata = 16'h1234; wr_stb = 1; #1;
        check("R14 buf_wr", {buf_wr, buf_wdata}, {1'b1, 16'h1234});
        @(negedge clk); wr_stb = 0; cs0 = 0;

        // R10
        hwrite(0, 1, 3'd6, 16'h0004); @(negedge clk);
        check("R10 srst out", srst_out, 1'b1);
        hread(1, 0, 3'd7); check("R10 busy in reset", rv[7:0], 8'hC0);
        hwrite(0, 1, 3'd6, 16'h0000);
        hread(0, 1, 3'd6); check("R10 busy after release", rv[7:0], 8'hC0);
        done_pulse(0, 8'h00);
        hread(1, 0, 3'd7); check("R10 ready", rv[7:0], 8'h40);
        hread(1, 0, 3'd2); check("R10 count default", rv[7:0], 8'h01);
        hread(1, 0, 3'd1); check("R10 error default", rv[7:0], 8'h01);
        hread(1, 0, 3'd6); check("R10 drvhd default", rv[7:0], 8'hA0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule